// File: doc/BRIEF.md
# Fused 4x4 Multiply-Accumulate Unit

This block multiplies two 4-bit unsigned operands and adds the product into an 8-bit running sum in one step. It does not finish the product before adding it. The sixteen AND-gate partial products and the eight bits of the current accumulator go as one bit set into a column compressor. That compressor is built only from instantiated full-adder cells. It reduces all 24 input bits to one bit per column of the 8-bit result. The result goes into a registered accumulator, and no carry-propagate adder follows the compressor.

Each column is reduced as its bits become available. The partial products and the accumulator bit go in first, and the carries from the column below go in last. Every carry that leaves the top column is dropped, so the sum wraps modulo 256. A synchronous clear zeroes the sum, and an enable decides whether a cycle accumulates. The unit is meant as the repeated primitive inside a larger matrix engine, which streams operand pairs into it and reads the running sum.

Top module: `mac_fused`

## Requirements
- R1: While rst_ni is low, acc_o is 0. The reset acts at once, without a clock edge.
- R2: On a rising edge with en_i=1 and clr_i=0, acc_o becomes (acc_o + a_i*b_i) mod 256. Both operands are unsigned 4-bit values.
- R3: acc_o changes only at a rising clock edge. A change on a_i, b_i or en_i between edges does not show on acc_o before the next edge.
- R4: On a rising edge with en_i=0 and clr_i=0, acc_o keeps its value whatever a_i and b_i carry.
- R5: On a rising edge with clr_i=1, acc_o becomes 0 whatever en_i is. Clear wins over enable.
- R6: Sums above 255 wrap. For example, 225 + 15*15 gives 194 and 100 + 12*13 gives 0.
- R7: An enabled cycle in which either operand is 0 leaves acc_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of the sum; wins over en_i |
| en_i | input | 1 | Accumulate enable |
| a_i | input | 4 | Unsigned multiplicand |
| b_i | input | 4 | Unsigned multiplier |
| acc_o | output | 8 | Registered running sum |

## Verification
The bench walks all 256 operand pairs three times without clearing in between. The running sum therefore enters each pair at many different values, and a bad cell in any column or a miswired carry fails for at least one pair. A short table of seeded cases sets the sum with one product and then adds a second. These cases hit exact wraps to zero, double wraps from the largest product, and zero operands, so they separate a dropped top carry from a wrong low column. Directed steps drive clear together with enable, drop enable while the operands change, change operands between edges, and pull reset without a clock. These steps separate a wrong clear priority, a missing hold and a combinational leak from the compressor.

// File: rtl/mac_pkg.sv
package mac_pkg;

  // partial-product bits of weight col
  function automatic int pp_cnt(int aw, int bw, int col);
    int n = 0;
    for (int i = 0; i < aw; i++)
      if (col - i >= 0 && col - i < bw) n++;
    return n;
  endfunction

  // slot of row's partial product within its column
  function automatic int pp_rank(int aw, int bw, int col, int row);
    int n = 0;
    for (int i = 0; i < row; i++)
      if (col - i >= 0 && col - i < bw) n++;
    return n;
  endfunction

  // full adders needed to bring column col down to one bit
  function automatic int fa_cnt(int aw, int bw, int col);
    int cin = 0;
    int n   = 0;
    for (int c = 0; c <= col; c++) begin
      n   = pp_cnt(aw, bw, c) + 1 + cin;
      cin = n / 2;
    end
    return cin;
  endfunction

  // carry-bus offset of column col
  function automatic int fa_off(int aw, int bw, int col);
    int s = 0;
    for (int c = 0; c < col; c++) s += fa_cnt(aw, bw, c);
    return s;
  endfunction

endpackage

// File: rtl/mac_fa_cell.sv
module mac_fa_cell (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic co_o
);
  logic p;
  assign p    = a_i ^ b_i;
  assign s_o  = p ^ c_i;
  assign co_o = (a_i & b_i) | (c_i & p);
endmodule

// File: rtl/mac_pp_array.sv
module mac_pp_array #(
  parameter int A_W = 4,
  parameter int B_W = 4
) (
  input  logic [A_W-1:0]     a_i,
  input  logic [B_W-1:0]     b_i,
  output logic [A_W*B_W-1:0] pp_o
);
  for (genvar i = 0; i < A_W; i++) begin : g_row
    for (genvar k = 0; k < B_W; k++) begin : g_bit
      assign pp_o[i*B_W + k] = a_i[i] & b_i[k];
    end
  end
endmodule

// File: rtl/mac_csa_tree.sv
module mac_csa_tree
  import mac_pkg::*;
#(
  parameter int A_W = 4,
  parameter int B_W = 4,
  parameter int S_W = 8
) (
  input  logic [A_W*B_W-1:0] pp_i,
  input  logic [S_W-1:0]     acc_i,
  output logic [S_W-1:0]     sum_o
);
  localparam int CY_W   = fa_off(A_W, B_W, S_W - 1);
  localparam int TOP_FA = fa_cnt(A_W, B_W, S_W - 1);
  localparam int TOP_W  = (TOP_FA > 0) ? TOP_FA : 1;

  logic [CY_W-1:0]  cy_bus;
  logic [TOP_W-1:0] unused_top_cy;

  if (TOP_FA == 0) begin : g_no_top
    assign unused_top_cy = '0;
  end

  for (genvar j = 0; j < S_W; j++) begin : g_col
    localparam int NPP = pp_cnt(A_W, B_W, j);
    localparam int NCI = (j == 0) ? 0 : fa_cnt(A_W, B_W, j - 1);
    localparam int NB  = NPP + 1 + NCI;
    localparam int NFA = NB / 2;
    localparam int OFF = fa_off(A_W, B_W, j);

    logic [NB-1:0] bits;
    logic [NFA:0]  run;

    // early bits first, late carries last
    for (genvar i = 0; i < A_W; i++) begin : g_pp
      if (j - i >= 0 && j - i < B_W) begin : g_on
        assign bits[pp_rank(A_W, B_W, j, i)] = pp_i[i*B_W + (j - i)];
      end
    end
    assign bits[NPP] = acc_i[j];
    if (NCI > 0) begin : g_cin
      assign bits[NB-1:NPP+1] = cy_bus[fa_off(A_W, B_W, j - 1) +: NCI];
    end

    assign run[0] = bits[0];
    for (genvar k = 0; k < NFA; k++) begin : g_fa
      logic cz, co;
      if (2*k + 2 < NB) begin : g_full
        assign cz = bits[2*k + 2];
      end else begin : g_pad
        assign cz = 1'b0;
      end
      mac_fa_cell u_fa (
        .a_i (run[k]),
        .b_i (bits[2*k + 1]),
        .c_i (cz),
        .s_o (run[k+1]),
        .co_o(co)
      );
      if (j < S_W - 1) begin : g_keep
        assign cy_bus[OFF + k] = co;
      end else begin : g_drop
        assign unused_top_cy[k] = co;
      end
    end
    assign sum_o[j] = run[NFA];
  end
endmodule

// File: rtl/mac_fused.sv
module mac_fused #(
  parameter int A_W   = 4,
  parameter int B_W   = 4,
  parameter int ACC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [A_W-1:0]   a_i,
  input  logic [B_W-1:0]   b_i,
  output logic [ACC_W-1:0] acc_o
);
  localparam int PP_N = A_W * B_W;

  logic [PP_N-1:0]  pp;
  logic [ACC_W-1:0] sum_next;
  logic [ACC_W-1:0] acc_q;

  mac_pp_array #(.A_W(A_W), .B_W(B_W)) u_pp (
    .a_i (a_i),
    .b_i (b_i),
    .pp_o(pp)
  );

  mac_csa_tree #(.A_W(A_W), .B_W(B_W), .S_W(ACC_W)) u_tree (
    .pp_i (pp),
    .acc_i(acc_q),
    .sum_o(sum_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (clr_i)  acc_q <= '0;
    else if (en_i)   acc_q <= sum_next;
  end

  assign acc_o = acc_q;

  a_r2_r6_fused_sum: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i) |=> acc_o == ACC_W'($past(acc_o)
                          + ACC_W'($past(a_i)) * ACC_W'($past(b_i))));

  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> $stable(acc_o));

  a_r5_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> acc_o == '0);

  a_r7_zero_operand: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i && (a_i == '0 || b_i == '0)) |=> $stable(acc_o));

  always_ff @(posedge clk_i) begin
    if (!rst_ni) a_r1_reset_zero: assert (acc_o == '0);
  end
endmodule

// File: tb/mac_fused_bench.sv
`timescale 1ns/1ps
module mac_fused_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       clr_i = 1'b0;
  logic       en_i = 1'b0;
  logic [3:0] a_i = '0;
  logic [3:0] b_i = '0;
  logic [7:0] acc_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  mac_fused u_mac_fused (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr_i),
    .en_i  (en_i),
    .a_i   (a_i),
    .b_i   (b_i),
    .acc_o (acc_o)
  );

  // {seed_a, seed_b, a, b, expected}
  localparam int NVEC = 8;
  localparam logic [23:0] VEC [NVEC] = '{
    {4'd0,  4'd0,  4'd15, 4'd15, 8'd225},
    {4'd15, 4'd15, 4'd15, 4'd15, 8'd194},
    {4'd10, 4'd10, 4'd12, 4'd13, 8'd0},
    {4'd5,  4'd7,  4'd0,  4'd9,  8'd35},
    {4'd3,  4'd3,  4'd1,  4'd1,  8'd10},
    {4'd15, 4'd14, 4'd11, 4'd6,  8'd20},
    {4'd8,  4'd8,  4'd8,  4'd8,  8'd128},
    {4'd13, 4'd11, 4'd9,  4'd14, 8'd13}
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic apply(input logic en, input logic clr,
                       input logic [3:0] a, input logic [3:0] b);
    @(negedge clk_i);
    en_i = en; clr_i = clr; a_i = a; b_i = b;
    @(posedge clk_i);
    #1;
  endtask

  initial begin
    int model;
    #1;
    check("R1 reset value", acc_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // seeded table: clear, seed by one product, add a second
    for (int v = 0; v < NVEC; v++) begin
      apply(1'b0, 1'b1, 4'd0, 4'd0);
      apply(1'b1, 1'b0, VEC[v][23:20], VEC[v][19:16]);
      apply(1'b1, 1'b0, VEC[v][15:12], VEC[v][11:8]);
      check($sformatf("R2/R6/R7 table %0d", v), acc_o, VEC[v][7:0]);
    end

    // exhaustive sweep, running sum never cleared between pairs
    for (int pass = 0; pass < 3; pass++) begin
      apply(1'b0, 1'b1, 4'd0, 4'd0);
      apply(1'b1, 1'b0, 4'(pass*4 + 3), 4'(pass*5 + 2));
      model = ((pass*4 + 3) * (pass*5 + 2)) % 256;
      for (int idx = 0; idx < 256; idx++) begin
        logic [3:0] a, b;
        a = idx[3:0];
        b = idx[7:4] ^ 4'(pass * 5);
        apply(1'b1, 1'b0, a, b);
        model = (model + int'(a) * int'(b)) % 256;
        check($sformatf("R2 sweep p%0d a=%0d b=%0d", pass, a, b), acc_o, model);
      end
    end

    // R4: enable low, operands moving
    apply(1'b0, 1'b1, 4'd0, 4'd0);
    apply(1'b1, 1'b0, 4'd9, 4'd7);
    check("R2 load 63", acc_o, 63);
    apply(1'b0, 1'b0, 4'd15, 4'd15);
    apply(1'b0, 1'b0, 4'd6, 4'd11);
    check("R4 hold with enable low", acc_o, 63);

    // R7: zero operand with enable
    apply(1'b1, 1'b0, 4'd0, 4'd15);
    apply(1'b1, 1'b0, 4'd12, 4'd0);
    check("R7 zero operand", acc_o, 63);

    // R3: operands change between edges
    @(negedge clk_i);
    en_i = 1'b1; clr_i = 1'b0; a_i = 4'd2; b_i = 4'd3;
    #1;
    check("R3 no change before edge", acc_o, 63);
    a_i = 4'd15; b_i = 4'd15;
    #1;
    check("R3 still no change", acc_o, 63);
    @(posedge clk_i);
    #1;
    check("R3 update at edge", acc_o, (63 + 225) % 256);

    // R5: clear beats enable
    apply(1'b1, 1'b1, 4'd15, 4'd15);
    check("R5 clear over enable", acc_o, 0);
    apply(1'b1, 1'b0, 4'd4, 4'd4);
    check("R2 after clear", acc_o, 16);
    apply(1'b0, 1'b1, 4'd4, 4'd4);
    check("R5 clear with enable low", acc_o, 0);

    // R6: wrap exactly to zero, then one past
    apply(1'b1, 1'b0, 4'd8, 4'd8);
    apply(1'b1, 1'b0, 4'd8, 4'd8);
    apply(1'b1, 1'b0, 4'd8, 4'd8);
    apply(1'b1, 1'b0, 4'd8, 4'd8);
    check("R6 wrap to zero", acc_o, 0);
    apply(1'b1, 1'b0, 4'd15, 4'd15);
    apply(1'b1, 1'b0, 4'd1, 4'd1);
    apply(1'b1, 1'b0, 4'd15, 4'd15);
    check("R6 wrap past 255", acc_o, (226 + 225) % 256);

    // R1: asynchronous reset mid-cycle
    en_i = 1'b0;
    @(negedge clk_i);
    #1;
    rst_ni = 1'b0;
    #1;
    check("R1 async reset", acc_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    apply(1'b1, 1'b0, 4'd3, 4'd5);
    check("R2 after reset", acc_o, 15);
    apply(1'b0, 1'b0, 4'd0, 4'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule